// File: doc/BRIEF.md
# Low-Side Pulse Stretcher with Bootstrap Refresh

This block sits between the internal PWM decision of a synchronous buck controller and the two gate-enable signals that drive the high-side and low-side switches. In normal operation it passes the PWM through with one clock of latency: the high side is on while the PWM is high, and the low side is on while it is low. During each low-side on period it raises an overcurrent monitor window. The window opens only after a blanking interval, so switching noise settles before the switch node is sampled, and it closes in the same cycle that the low side turns off.

With overcurrent protection enabled, the block counts how often a switching period's low-side time comes out too short to give a useful sample. When this happens in three periods in a row, the third low-side pulse is extended past the period boundary to a guaranteed minimum width. If that period had no low-side time at all, a pulse of the minimum width is inserted. The high side is held off while the extension runs, so its on time shrinks accordingly. Separately, and whether protection is on or off, a high side that stays on without a break for too long triggers a low-side pulse lasting one full switching period, so that the bootstrap capacitor can recharge.

Top module: `ls_stretch_refresh`

## Requirements
- R1: Outside of forced intervals, hsEn equals pwmIn and lsEn equals the inverse of pwmIn, each delayed by one clock.
- R2: hsEn and lsEn are never both high in the same cycle.
- R3: monWin is high only while lsEn is high. It rises on the cycle after lsEn has been high for BLANK_CYC (10) cycles in a row, stays high while lsEn stays high, and is low in the cycle lsEn falls.
- R4: A switching period ends on a clock with cycTick high. The period counts as narrow when the number of its cycles with pwmIn low, including the tick cycle, is below BLANK_CYC+SAMPLE_CYC (14). A count of exactly 14 is not narrow.
- R5: With ocpEn high, a period that is the third narrow one in a row extends lsEn for MIN_LS_CYC (21) minus its low count, starting on the cycle after the period ends. A period with no low time therefore gets an inserted 21-cycle pulse.
- R6: A period that is not narrow clears the run of narrow periods, so three more narrow periods are needed before the next extension.
- R7: During a forced low-side interval, hsEn stays low even when pwmIn is high, which shortens the high-side on time by the forced length.
- R8: While ocpEn is low, no extension or insertion takes place and the narrow run is cleared.
- R9: Once hsEn has been high for REFRESH_CYC (5000) consecutive cycles, lsEn is forced high for exactly one switching period, starting after the next period boundary. This happens regardless of ocpEn.
- R10: While rst is high, hsEn, lsEn and monWin are low one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| pwmIn | input | 1 | Internal PWM decision, high selects the high side |
| cycTick | input | 1 | High on the last clock of each switching period |
| ocpEn | input | 1 | Overcurrent protection enabled, gates pulse extension |
| hsEn | output | 1 | High-side switch enable |
| lsEn | output | 1 | Low-side switch enable |
| monWin | output | 1 | Overcurrent monitor window |

## Verification
If the narrow-period run count is wrong, the effect shows at the ports within three switching periods: an extended low-side pulse appears one period early or late, and the high-side pulse that follows changes length by the same amount. If the extension length is computed wrongly, the low-side count of the following period changes right away. A fault in the blanking counter moves the edge of monWin on the very first low-side pulse. A fault in the refresh counter only becomes visible after about REFRESH_CYC cycles of continuous high-side on time, so the bench holds pwmIn high long enough for two refresh events to occur.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStretch;   // start a low-side extension at this period end
    logic refreshHold;   // force low side for the current period
  } lsrStrobe_t;

  // Conditions reported by the datapath to control
  typedef struct packed {
    logic narrowNow;     // low time of the ending period is below threshold
    logic hsLong;        // high side has been on past the refresh limit
  } lsrStatus_t;

endpackage

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int BLANK_CYC   = 10,
  parameter int SAMPLE_CYC  = 4,
  parameter int MIN_LS_CYC  = 21,
  parameter int REFRESH_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwmIn,
  input  logic       cycTick,
  input  lsrStrobe_t strobe,
  output lsrStatus_t status,
  output logic       hsEn,
  output logic       lsEn,
  output logic       monWin
);

  localparam int NARROW_LIM = BLANK_CYC + SAMPLE_CYC;
  localparam int LOW_W      = $clog2(NARROW_LIM + 1);
  localparam int SUM_W      = LOW_W + 1;
  localparam int EXT_W      = $clog2(MIN_LS_CYC + 1);
  localparam int RUN_MAX    = BLANK_CYC + 1;
  localparam int RUN_W      = $clog2(RUN_MAX + 1);
  localparam int HS_W       = $clog2(REFRESH_CYC + 1);

  logic [LOW_W-1:0] lowCnt;
  logic [SUM_W-1:0] lowSum;
  logic [EXT_W-1:0] stretchRem;
  logic [EXT_W-1:0] extAmt;
  logic [HS_W-1:0]  hsRun;
  logic [RUN_W-1:0] lsRun;
  logic [RUN_W-1:0] lsRunNext;
  logic             forceLs;
  logic             hsNext;
  logic             lsNext;

  always_comb begin
    // low-time of the period so far, including the current cycle
    lowSum  = SUM_W'(lowCnt) + SUM_W'(!pwmIn);
    extAmt  = EXT_W'(MIN_LS_CYC) - EXT_W'(lowSum);
    forceLs = (stretchRem != '0) || strobe.refreshHold;
    hsNext  = pwmIn && !forceLs;
    lsNext  = !pwmIn || forceLs;

    if (!lsNext)                        lsRunNext = '0;
    else if (!lsEn)                     lsRunNext = RUN_W'(1);
    else if (lsRun == RUN_W'(RUN_MAX))  lsRunNext = lsRun;
    else                                lsRunNext = lsRun + RUN_W'(1);

    status.narrowNow = lowSum < SUM_W'(NARROW_LIM);
    status.hsLong    = hsRun >= HS_W'(REFRESH_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lowCnt     <= '0;
      stretchRem <= '0;
      hsRun      <= '0;
      lsRun      <= '0;
      hsEn       <= 1'b0;
      lsEn       <= 1'b0;
      monWin     <= 1'b0;
    end else begin
      if (cycTick)
        lowCnt <= '0;
      else if (!pwmIn && lowCnt != LOW_W'(NARROW_LIM))
        lowCnt <= lowCnt + LOW_W'(1);

      if (strobe.loadStretch)
        stretchRem <= extAmt;
      else if (stretchRem != '0)
        stretchRem <= stretchRem - EXT_W'(1);

      if (!hsEn)
        hsRun <= '0;
      else if (hsRun != HS_W'(REFRESH_CYC))
        hsRun <= hsRun + HS_W'(1);

      hsEn   <= hsNext;
      lsEn   <= lsNext;
      lsRun  <= lsRunNext;
      monWin <= lsNext && (lsRunNext > RUN_W'(BLANK_CYC));
    end
  end

endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int NARROW_RUN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycTick,
  input  logic       ocpEn,
  input  lsrStatus_t status,
  output lsrStrobe_t strobe
);

  localparam int CNT_W = $clog2(NARROW_RUN + 1);

  logic [CNT_W-1:0] narrowCnt;
  logic             refreshAct;

  always_comb begin
    strobe.loadStretch = cycTick && ocpEn && status.narrowNow &&
                         (narrowCnt == CNT_W'(NARROW_RUN - 1));
    strobe.refreshHold = refreshAct;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      narrowCnt  <= '0;
      refreshAct <= 1'b0;
    end else begin
      if (!ocpEn)
        narrowCnt <= '0;
      else if (cycTick) begin
        if (!status.narrowNow || strobe.loadStretch)
          narrowCnt <= '0;
        else
          narrowCnt <= narrowCnt + CNT_W'(1);
      end

      // a refresh lasts from one period boundary to the next
      if (cycTick)
        refreshAct <= !refreshAct && status.hsLong;
    end
  end

endmodule

// File: rtl/ls_stretch_refresh.sv
module ls_stretch_refresh
  import lsr_pkg::*;
#(
  parameter int BLANK_CYC   = 10,
  parameter int SAMPLE_CYC  = 4,
  parameter int MIN_LS_CYC  = 21,
  parameter int REFRESH_CYC = 5000,
  parameter int NARROW_RUN  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwmIn,
  input  logic cycTick,
  input  logic ocpEn,
  output logic hsEn,
  output logic lsEn,
  output logic monWin
);

  lsrStrobe_t strobe;
  lsrStatus_t status;

  lsr_ctrl #(
    .NARROW_RUN(NARROW_RUN)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .cycTick(cycTick),
    .ocpEn  (ocpEn),
    .status (status),
    .strobe (strobe)
  );

  lsr_datapath #(
    .BLANK_CYC  (BLANK_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .MIN_LS_CYC (MIN_LS_CYC),
    .REFRESH_CYC(REFRESH_CYC)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .pwmIn  (pwmIn),
    .cycTick(cycTick),
    .strobe (strobe),
    .status (status),
    .hsEn   (hsEn),
    .lsEn   (lsEn),
    .monWin (monWin)
  );

endmodule

// File: rtl/lsr_checker.sv
module lsr_checker (
  input logic clk,
  input logic rst,
  input logic pwmIn,
  input logic hsEn,
  input logic lsEn,
  input logic monWin
);

  p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(hsEn && lsEn));

  p_hs_needs_pwm_r1: assert property (@(posedge clk) disable iff (rst)
    hsEn |-> $past(pwmIn));

  p_ls_on_pwm_low_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pwmIn)) |-> lsEn);

  p_window_in_ls_r3: assert property (@(posedge clk) disable iff (rst)
    monWin |-> lsEn);

  p_window_blank_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lsEn) |-> !monWin);

  p_window_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (lsEn && $past(lsEn) && $past(monWin)) |-> monWin);

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!hsEn && !lsEn && !monWin));

endmodule

bind ls_stretch_refresh lsr_checker chk_i (
  .clk   (clk),
  .rst   (rst),
  .pwmIn (pwmIn),
  .hsEn  (hsEn),
  .lsEn  (lsEn),
  .monWin(monWin)
);

// File: tb/ls_stretch_refresh_tb_top.sv
`timescale 1ns/1ps
module ls_stretch_refresh_tb_top;

  localparam int BLANK   = 10;
  localparam int REFRESH = 5000;
  localparam int PER     = 50;
  localparam int NVEC    = 27;

  // {high cycles, low cycles, ocpEn, expected lsEn cycles, requirement}
  localparam int VEC [NVEC][5] = '{
    '{30, 20, 1, 20, 1},
    '{30, 20, 1, 20, 1},
    '{45,  5, 1,  5, 4},
    '{45,  5, 1,  5, 4},
    '{45,  5, 1,  5, 5},
    '{45,  5, 1, 21, 5},
    '{45,  5, 1,  5, 4},
    '{45,  5, 1,  5, 5},
    '{40, 10, 1, 26, 7},
    '{30, 20, 1, 20, 6},
    '{45,  5, 1,  5, 6},
    '{45,  5, 1,  5, 6},
    '{30, 20, 1, 20, 6},
    '{45,  5, 1,  5, 6},
    '{45,  5, 1,  5, 6},
    '{45,  5, 0,  5, 8},
    '{45,  5, 1,  5, 8},
    '{45,  5, 1,  5, 8},
    '{50,  0, 1,  0, 5},
    '{50,  0, 1, 21, 5},
    '{50,  0, 1,  0, 5},
    '{50,  0, 1,  0, 5},
    '{36, 14, 1, 35, 4},
    '{37, 13, 1, 13, 4},
    '{37, 13, 1, 13, 4},
    '{37, 13, 1, 13, 5},
    '{30, 20, 1, 28, 7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwmIn = 1'b1;
  logic cycTick = 1'b0;
  logic ocpEn = 1'b1;
  logic hsEn, lsEn, monWin;

  int checks = 0;
  int fails = 0;
  int lsCnt, hsCnt;
  int lsRunT = 0, hsRunT = 0;
  int lastLsPulse = 0, lastHsPulse = 0;
  bit lsDone = 0;
  int exclErr = 0, winErr = 0, monRun = 0;
  int refreshSeen;

  always #10 clk = ~clk;

  ls_stretch_refresh dut_i (
    .clk(clk), .rst(rst), .pwmIn(pwmIn), .cycTick(cycTick), .ocpEn(ocpEn),
    .hsEn(hsEn), .lsEn(lsEn), .monWin(monWin)
  );

  function automatic string tagName(input int n);
    return $sformatf("R%0d", n);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // continuous observation: exclusivity (R2) and window rule (R3)
  always @(negedge clk) begin
    if (lsEn) monRun++; else monRun = 0;
    if (!rst) begin
      if (hsEn && lsEn) exclErr++;
      if (monWin != (lsEn && monRun > BLANK)) winErr++;
    end
  end

  task automatic step(input logic p, input logic t);
    pwmIn = p;
    cycTick = t;
    @(negedge clk);
    if (lsEn) lsCnt++;
    if (hsEn) hsCnt++;
    if (lsEn) lsRunT++;
    else if (lsRunT != 0) begin lastLsPulse = lsRunT; lsDone = 1; lsRunT = 0; end
    if (hsEn) hsRunT++;
    else if (hsRunT != 0) begin lastHsPulse = hsRunT; hsRunT = 0; end
  endtask

  task automatic runPeriod(input int hi, input int lo);
    lsCnt = 0;
    hsCnt = 0;
    for (int i = 0; i < hi + lo; i++)
      step(i < hi, i == hi + lo - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: quiet outputs in reset
    check(hsEn == 1'b0, "R10 hsEn in reset", hsEn, 0);
    check(lsEn == 1'b0, "R10 lsEn in reset", lsEn, 0);
    check(monWin == 1'b0, "R10 monWin in reset", monWin, 0);
    rst = 1'b0;

    // table walk: R1 pass-through, R4 threshold, R5 stretch/insert,
    // R6 run clear, R7 high side shortened, R8 disable
    for (int v = 0; v < NVEC; v++) begin
      ocpEn = VEC[v][2][0];
      runPeriod(VEC[v][0], VEC[v][1]);
      check(lsCnt == VEC[v][3], $sformatf("%s vec%0d lsEn cycles", tagName(VEC[v][4]), v),
            lsCnt, VEC[v][3]);
      check(hsCnt == PER - VEC[v][3], $sformatf("R7 vec%0d hsEn cycles", v),
            hsCnt, PER - VEC[v][3]);
    end

    // R9: boot refresh with protection off and PWM stuck high
    ocpEn = 1'b0;
    runPeriod(PER, 0);
    lsDone = 0;
    refreshSeen = 0;
    for (int k = 0; k < 220; k++) begin
      runPeriod(PER, 0);
      if (lsDone) begin
        lsDone = 0;
        refreshSeen++;
        check(lastLsPulse == PER, "R9 refresh pulse width", lastLsPulse, PER);
        check(lastHsPulse >= REFRESH && lastHsPulse <= REFRESH + PER,
              "R9 high-side run before refresh", lastHsPulse, REFRESH);
      end
    end
    check(refreshSeen == 2, "R9 refresh count", refreshSeen, 2);

    check(exclErr == 0, "R2 overlap cycles", exclErr, 0);
    check(winErr == 0, "R3 window mismatches", winErr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule